// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a virtual address into a physical address. It splits the address into a virtual page number and a page offset. It compares the page number with every stored entry at once, and on a match it returns the stored physical page number joined to the unchanged offset. Every entry holds the following state beside its translation:

- a valid bit
- a present bit
- a dirty bit
- a recently-used bit
- read, write and execute rights

A single lookup therefore also checks the access rights, marks the page dirty on a permitted write and refreshes the usage state.

Lookups enter on a valid/ready channel. `req_ready` is high whenever no miss is outstanding, so a request is taken on any clock edge where both `req_valid` and `req_ready` are high.

Exactly one cycle after it is taken, the request produces a one-cycle `rsp_valid` pulse. This response cannot be stalled. It carries one of four outcomes: hit, miss, page fault or protection fault.

When a lookup misses:

- The block raises `walk_req` with the missing page number and drops `req_ready`.
- An external page-table walker later returns the entry on a second valid/ready channel (`walk_valid`/`walk_ready`).
- The block installs that entry in a victim slot chosen from the usage bits.
- The requester then issues the same access again.

Top module: `tlb_xlate`

## Requirements
- R1: At most one stored valid entry matches any incoming page number; a matching access reports the index of that entry on `rsp_way`.
- R2: On a hit, `rsp_paddr` equals the entry's physical page number in the upper bits with the request's low `OFF_W` offset bits copied unchanged.
- R3: Rights are checked on the access kind. `req_acc` 0 is a read and needs rights bit 0. Code 1 is a write and needs bit 1. Code 2 is an execute and needs bit 2. On a present entry lacking the needed right, the response raises `rsp_prot_fault` with `rsp_hit` low.
- R4: A matching entry whose present bit is clear raises `rsp_page_fault`, with `rsp_hit` and `rsp_prot_fault` low. The present check takes priority over the rights check.
- R5: A request with no matching valid entry produces a response with only `rsp_miss` set. From the next cycle, `walk_req` is high and `walk_vpn` holds the missing page number, stable until the refill. `req_ready` is low for that whole time.
- R6: A refill is taken when `walk_valid` is high while `walk_req` is high. It writes the returned entry into the victim slot and clears `walk_req`. The retried access then hits.
- R7: A permitted write sets the entry's dirty bit. `rsp_dirty` reports the entry's dirty bit after the access; it is low on a miss.
- R8: An entry's usage bit is set on every matching lookup and on its refill. If that leaves all usage bits set, every usage bit except that entry's is cleared. The victim is the lowest-index entry that is invalid or has a clear usage bit.
- R9: A one-cycle `inv_all` pulse clears every valid bit, so that every following lookup misses until entries are refilled.
- R10: After reset, all entries are invalid, `rsp_valid` and `walk_req` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup accepted when high |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_hit | output | 1 | Translation granted |
| rsp_miss | output | 1 | No matching entry |
| rsp_page_fault | output | 1 | Match on a non-present page |
| rsp_prot_fault | output | 1 | Match lacking the needed right |
| rsp_paddr | output | PPN_W+OFF_W | Physical address on a hit |
| rsp_way | output | $clog2(ENTRIES) | Index of the matching entry |
| rsp_dirty | output | 1 | Dirty bit of the matching entry after the access |
| walk_req | output | 1 | Refill wanted (valid toward the walker) |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_ready | output | 1 | Refill accepted when high |
| walk_valid | input | 1 | Refill data valid |
| walk_ppn | input | PPN_W | Returned physical page number |
| walk_perm | input | 3 | Returned rights: bit 0 read, 1 write, 2 execute |
| walk_present | input | 1 | Returned present bit |
| walk_dirty | input | 1 | Returned dirty bit |

## Verification
Directed stimulus does three things:

- It fills the buffer in order, which checks that a full usage vector collapses to the newest entry and that the next miss evicts slot 0.
- It makes one access each that is denied by rights, by absence and by nothing, which separates R3, R4 and R7.
- It pulses invalidate and then looks up a page that was just present, which separates R9 from ordinary eviction.

Random access kinds over a page pool larger than the buffer then mix hits, faults, misses and refills. This exposes any error in victim order or dirty tracking through `rsp_way`, `rsp_paddr` and `rsp_dirty`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;
  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int N  = 8,
  parameter int VW = 20,
  localparam int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][VW-1:0] tags,
  input  logic [VW-1:0]        key,
  output logic [N-1:0]         match,
  output logic                 any,
  output logic [IW-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) idx = idx | IW'(i);
  end

  // At most one entry may ever match the key
  assert_unique_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/tlb_use_update.sv
module tlb_use_update #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  used,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  output logic [N-1:0]  nxt_used
);
  always_comb begin
    nxt_used = used;
    if (set_en) begin
      nxt_used[set_idx] = 1'b1;
      if (&nxt_used) begin
        nxt_used          = '0;
        nxt_used[set_idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  used,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid[i] || !used[i]) idx = IW'(i);
  end

  // The usage vector never saturates, so a clear slot always exists
  assert_victim_exists_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used) < N);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int OFF_W   = 12,
  localparam int IW   = $clog2(ENTRIES),
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_page_fault,
  output logic              rsp_prot_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [IW-1:0]     rsp_way,
  output logic              rsp_dirty,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic              walk_ready,
  input  logic              walk_valid,
  input  logic [PPN_W-1:0]  walk_ppn,
  input  logic [2:0]        walk_perm,
  input  logic              walk_present,
  input  logic              walk_dirty
);
  logic [ENTRIES-1:0]             ent_valid, ent_pres, ent_dirty, ent_used;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
  logic [ENTRIES-1:0][2:0]        ent_perm;
  logic                           pend_q;
  logic [VPN_W-1:0]               walk_vpn_q;

  logic [VPN_W-1:0]   vpn_in;
  logic [OFF_W-1:0]   off_in;
  logic [ENTRIES-1:0] match;
  logic               any;
  logic [IW-1:0]      hidx, vic;
  logic               acc_fire, refill, right_ok, pres_ok, grant, is_wr;
  logic               use_set_en;
  logic [IW-1:0]      use_set_idx;
  logic [ENTRIES-1:0] nxt_used;

  assign vpn_in     = req_vaddr[VA_W-1:OFF_W];
  assign off_in     = req_vaddr[OFF_W-1:0];
  assign req_ready  = !pend_q;
  assign acc_fire   = req_valid && req_ready;
  assign walk_req   = pend_q;
  assign walk_vpn   = walk_vpn_q;
  assign walk_ready = pend_q;
  assign refill     = walk_valid && pend_q;

  tlb_cam_match #(.N(ENTRIES), .VW(VPN_W)) u_cam (
    .clk(clk), .rst_n(rst_n), .valid(ent_valid), .tags(ent_vpn), .key(vpn_in),
    .match(match), .any(any), .idx(hidx));

  tlb_victim_pick #(.N(ENTRIES)) u_vic (
    .clk(clk), .rst_n(rst_n), .valid(ent_valid), .used(ent_used), .idx(vic));

  always_comb begin
    case (req_acc)
      ACC_WR:  right_ok = ent_perm[hidx][RIGHT_W];
      ACC_EX:  right_ok = ent_perm[hidx][RIGHT_X];
      default: right_ok = ent_perm[hidx][RIGHT_R];
    endcase
  end

  assign pres_ok     = ent_pres[hidx];
  assign grant       = any && pres_ok && right_ok;
  assign is_wr       = (req_acc == ACC_WR);
  assign use_set_en  = (acc_fire && any) || refill;
  assign use_set_idx = refill ? vic : hidx;

  tlb_use_update #(.N(ENTRIES)) u_use (
    .used(ent_used), .set_en(use_set_en), .set_idx(use_set_idx), .nxt_used(nxt_used));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0; ent_pres <= '0; ent_dirty <= '0; ent_used <= '0;
      ent_vpn <= '0; ent_ppn <= '0; ent_perm <= '0;
      pend_q <= 1'b0; walk_vpn_q <= '0;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0;
      rsp_page_fault <= 1'b0; rsp_prot_fault <= 1'b0;
      rsp_paddr <= '0; rsp_way <= '0; rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= acc_fire;
      if (acc_fire) begin
        rsp_hit        <= grant;
        rsp_miss       <= !any;
        rsp_page_fault <= any && !pres_ok;
        rsp_prot_fault <= any && pres_ok && !right_ok;
        rsp_paddr      <= {ent_ppn[hidx], off_in};
        rsp_way        <= hidx;
        rsp_dirty      <= any && (ent_dirty[hidx] || (grant && is_wr));
        if (grant && is_wr) ent_dirty[hidx] <= 1'b1;
        if (!any) begin
          pend_q     <= 1'b1;
          walk_vpn_q <= vpn_in;
        end
      end
      if (refill) begin
        ent_valid[vic] <= 1'b1;
        ent_vpn[vic]   <= walk_vpn_q;
        ent_ppn[vic]   <= walk_ppn;
        ent_perm[vic]  <= walk_perm;
        ent_pres[vic]  <= walk_present;
        ent_dirty[vic] <= walk_dirty;
        pend_q         <= 1'b0;
      end
      if (use_set_en) ent_used <= nxt_used;
      if (inv_all) ent_valid <= '0;
    end
  end

  // A miss opens a walk and blocks further lookups
  assert_miss_opens_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !any) |=> (walk_req && !req_ready));
  // The walk page number holds until the refill is taken
  assert_walk_vpn_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_valid) |=> $stable(walk_vpn));
  // A refill ends the outstanding walk
  assert_refill_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_valid && !(req_valid && req_ready)) |=> !walk_req);
  // Each response carries exactly one outcome
  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault}) == 1));
  // A granted write reports the page dirty
  assert_write_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && grant && is_wr) |=> (rsp_hit && rsp_dirty));
  // Invalidate empties the whole buffer
  assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (ent_valid == '0));
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  localparam int N = 8;
  localparam int VPN_W = 20, PPN_W = 16, OFF_W = 12;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, inv_all = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VPN_W+OFF_W-1:0] req_vaddr = '0;
  logic [1:0] req_acc = 2'd0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault, rsp_dirty;
  logic [PPN_W+OFF_W-1:0] rsp_paddr;
  logic [IW-1:0] rsp_way;
  logic walk_req, walk_ready;
  logic [VPN_W-1:0] walk_vpn;
  logic walk_valid = 1'b0, walk_present = 1'b0, walk_dirty = 1'b0;
  logic [PPN_W-1:0] walk_ppn = '0;
  logic [2:0] walk_perm = '0;

  always #2.5 clk = ~clk;

  tlb_xlate #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault),
    .rsp_paddr(rsp_paddr), .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ready(walk_ready),
    .walk_valid(walk_valid), .walk_ppn(walk_ppn), .walk_perm(walk_perm),
    .walk_present(walk_present), .walk_dirty(walk_dirty));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference state of the buffer, kept from the requirements
  bit               m_v[N], m_pres[N], m_dirty[N], m_used[N];
  logic [VPN_W-1:0] m_vpn[N];
  logic [PPN_W-1:0] m_ppn[N];
  logic [2:0]       m_perm[N];

  function automatic logic [PPN_W-1:0] pt_ppn(input logic [VPN_W-1:0] v);
    return PPN_W'(v * 37 + 16'h0A50);
  endfunction
  function automatic logic [2:0] pt_perm(input logic [VPN_W-1:0] v);
    return {v[1], v[0], 1'b1};
  endfunction
  function automatic bit pt_pres(input logic [VPN_W-1:0] v);
    return (v % 7) != 3;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i] || !m_used[i]) return i;
    return 0;
  endfunction

  task automatic m_touch(input int k);
    bit all;
    m_used[k] = 1'b1;
    all = 1'b1;
    for (int i = 0; i < N; i++) all &= m_used[i];
    if (all) for (int i = 0; i < N; i++) m_used[i] = (i == k);
  endtask

  task automatic access(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input logic [1:0] acc, input string ctx);
    for (int att = 0; att < 2; att++) begin
      int h, vic;
      bit found, pok, pres, gr;
      found = 1'b0; h = 0;
      for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) begin found = 1'b1; h = i; end
      chk({ctx, " R5 ready before request"}, req_ready, 1);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {vpn, off}; req_acc = acc;
      @(negedge clk);
      req_valid = 1'b0;
      chk({ctx, " R5 rsp_valid"}, rsp_valid, 1);
      if (!found) begin
        chk({ctx, " R5 miss outcome"}, {rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault}, 4'b0100);
        chk({ctx, " R7 dirty low on miss"}, rsp_dirty, 0);
        chk({ctx, " R5 walk_req"}, walk_req, 1);
        chk({ctx, " R5 walk_vpn"}, walk_vpn, vpn);
        chk({ctx, " R5 ready low"}, req_ready, 0);
        repeat (1 + ($urandom % 3)) @(negedge clk);
        chk({ctx, " R5 walk_vpn held"}, walk_vpn, vpn);
        walk_valid = 1'b1; walk_ppn = pt_ppn(vpn); walk_perm = pt_perm(vpn);
        walk_present = pt_pres(vpn); walk_dirty = 1'b0;
        @(negedge clk);
        walk_valid = 1'b0;
        vic = m_victim();
        m_v[vic] = 1'b1; m_vpn[vic] = vpn; m_ppn[vic] = pt_ppn(vpn);
        m_perm[vic] = pt_perm(vpn); m_pres[vic] = pt_pres(vpn); m_dirty[vic] = 1'b0;
        m_touch(vic);
        chk({ctx, " R6 walk closed"}, walk_req, 0);
        chk({ctx, " R6 ready again"}, req_ready, 1);
      end else begin
        pres = m_pres[h];
        case (acc)
          2'd1: pok = m_perm[h][1];
          2'd2: pok = m_perm[h][2];
          default: pok = m_perm[h][0];
        endcase
        gr = pres && pok;
        chk({ctx, " R6 R3 R4 outcome"}, {rsp_hit, rsp_miss, rsp_page_fault, rsp_prot_fault},
            {gr, 1'b0, !pres, pres && !pok});
        chk({ctx, " R1 R8 way"}, rsp_way, h);
        if (gr) chk({ctx, " R2 paddr"}, rsp_paddr, {m_ppn[h], off});
        if (gr && acc == 2'd1) m_dirty[h] = 1'b1;
        chk({ctx, " R7 dirty"}, rsp_dirty, m_dirty[h]);
        m_touch(h);
        break;
      end
    end
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_pres[i] = 0; m_dirty[i] = 0; m_used[i] = 0;
      m_vpn[i] = '0; m_ppn[i] = '0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    chk("R10 reset walk_req", walk_req, 0);
    chk("R10 reset req_ready", req_ready, 1);
    access(20'd1, 12'h123, 2'd0, "R10 first lookup misses");

    for (int v = 2; v <= 8; v++) access(VPN_W'(v), 12'h010, 2'd0, "fill");
    access(20'd9, 12'hFFF, 2'd0, "R8 evict after saturation");
    access(20'd1, 12'h000, 2'd0, "R8 refetch");
    access(20'd5, 12'h7A5, 2'd1, "R7 write granted");
    access(20'd5, 12'h7A5, 2'd0, "R7 dirty kept");
    access(20'd4, 12'h001, 2'd1, "R3 write denied");
    access(20'd6, 12'h002, 2'd2, "R3 execute granted");
    access(20'd4, 12'h003, 2'd2, "R3 execute denied");
    access(20'd10, 12'h004, 2'd0, "R4 absent page");
    access(20'd8, 12'h005, 2'd0, "R2 hit");
    pulse_inv();
    access(20'd8, 12'h006, 2'd0, "R9 after invalidate");

    for (int k = 0; k < 400; k++) begin
      if ($urandom % 60 == 0) pulse_inv();
      access(VPN_W'(1 + $urandom % 14), OFF_W'($urandom), 2'($urandom % 3), "random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule